// File: doc/BRIEF.md
# Linked-List Power Sequence Engine

This block plays back power-transition scripts held in a small byte-addressed instruction store. A script is a chain of four-byte steps. Each step carries a 16-bit power-bus message, a delay count and the index of the step that follows. Four start-index registers set where a script begins. They serve entry to sleep, wake from processor groups 1 and 2, wake from group 3, and warm reset. When a trigger is accepted, the engine emits each message on a parallel output with a one-clock strobe. It then waits out that step's delay, counted in ticks of an external prescaled enable, and follows the link. It stops at the end marker, or with an error on a link that leads outside the store.

A host fills the store indirectly. It writes a byte address to an address register, then writes the byte itself through a data register. The start registers sit behind the same write port. Messages pass through verbatim. Receivers decode them, and the usual layouts put the device group in bits 15:13 and the message kind in bit 12.

Top module: `pwr_seq_engine`

## Requirements
- R1: A host write with `host_sel`=0 loads the byte address register. A write with `host_sel`=1 stores `host_wdata` at the byte the address register names. It leaves the address register unchanged, with no auto-increment. Codes 6 and 7 write nothing.
- R2: Step n occupies bytes 4n..4n+3. Byte 4n is the message high byte, 4n+1 the message low byte, 4n+2 the delay, and 4n+3 the next step index.
- R3: Start registers are written with `host_sel` 2 (sleep entry), 3 (wake, groups 1 and 2), 4 (wake, group 3) and 5 (warm reset). Each holds a full byte.
- R4: An accepted trigger raises `busy` one clock after the trigger is sampled. The first message strobe follows one clock later, using the step at the selected start index.
- R5: `msg_valid` is high for exactly one clock per step. `msg_data` changes only together with that strobe and holds its value until the next step.
- R6: After a step with delay d, the next step's message follows the (d+1)-th `tick` seen while waiting. A delay of 0 therefore advances on the first tick. A `tick` in the fetch clock is not counted.
- R7: A link value of 0x3F ends the script after that step's delay: `busy` falls on the clock of the last counted tick.
- R8: A link that is neither 0x3F nor below 2**INDEX_W (with INDEX_W=6, any of 0x40..0xFF) ends the script after the delay and sets `err_flag`. A start value at or above 2**INDEX_W sets `err_flag` at once, and no message is emitted. `err_flag` clears on the next accepted trigger.
- R9: Triggers that arrive while `busy` is high are ignored.
- R10: When several triggers arrive in the same clock while idle, warm reset wins, then sleep entry, then wake for groups 1 and 2, then wake for group 3 (WARM_FIRST=1).
- R11: After reset `busy`, `msg_valid`, `err_flag` and `msg_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 3 | Host register code: 0 address, 1 data, 2..5 start registers |
| host_wdata | input | 8 | Host write byte |
| trig_sleep | input | 1 | Active-to-sleep trigger |
| trig_wake12 | input | 1 | Sleep-to-active trigger, groups 1 and 2 |
| trig_wake3 | input | 1 | Sleep-to-active trigger, group 3 |
| trig_warm | input | 1 | Warm reset trigger |
| tick | input | 1 | Prescaled delay time base |
| msg_data | output | 16 | Current power-bus message |
| msg_valid | output | 1 | One-clock strobe per emitted message |
| busy | output | 1 | Script in progress |
| err_flag | output | 1 | Script aborted on an out-of-range index |

## Verification
The bench builds the block with its defaults, INDEX_W=6 and WARM_FIRST=1. With INDEX_W=6 the byte address register is a full eight bits and step 63 is addressable. The end marker 0x3F is then also a legal start index, and every link from 0x40 up lands in the error range. The warm-first arbitration variant lets same-clock trigger collisions check the documented winner. A start byte above the store size brings the immediate-error path within reach.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
   localparam int BYTE_W = 8;
   localparam int MSG_W  = 16;
   localparam logic [BYTE_W-1:0] END_MARK = 8'h3F;

   typedef enum logic [2:0] {
      SEL_ADDR   = 3'd0,
      SEL_DATA   = 3'd1,
      SEL_SLEEP  = 3'd2,
      SEL_WAKE12 = 3'd3,
      SEL_WAKE3  = 3'd4,
      SEL_WARM   = 3'd5
   } host_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WAIT  = 2'd2
   } walk_st_e;

   typedef struct packed {
      logic [MSG_W-1:0]  msg;
      logic [BYTE_W-1:0] dly;
      logic [BYTE_W-1:0] link;
   } step_t;
endpackage

// File: rtl/pseq_store.sv
module pseq_store
   import pseq_pkg::*;
#(
   parameter int INDEX_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_we,
   input  logic [2:0]         host_sel,
   input  logic [BYTE_W-1:0]  host_wdata,
   input  logic [INDEX_W-1:0] rd_idx,
   output step_t              rd_step
);
   localparam int NUM_INS = 1 << INDEX_W;
   localparam int BYTES   = NUM_INS * 4;
   localparam int AW      = INDEX_W + 2;

   logic [BYTE_W-1:0] mem [BYTES];
   logic [AW-1:0]     addr_q;
   logic [BYTE_W-1:0] rd_byte [4];

   // R1: indirect write, the address register only moves on its own code
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         for (int i = 0; i < BYTES; i++) mem[i] <= '0;
      end else if (host_we) begin
         if (host_sel == SEL_ADDR) addr_q <= host_wdata[AW-1:0];
         if (host_sel == SEL_DATA) mem[addr_q] <= host_wdata;
      end
   end

   // R2: four byte lanes of one step, lane k at byte 4n+k
   for (genvar k = 0; k < 4; k++) begin : g_lane
      logic [AW-1:0] lane_addr;
      assign lane_addr  = {rd_idx, 2'(k)};
      assign rd_byte[k] = mem[lane_addr];
   end

   assign rd_step = '{msg:  {rd_byte[0], rd_byte[1]},
                      dly:  rd_byte[2],
                      link: rd_byte[3]};
endmodule

// File: rtl/pseq_starts.sv
module pseq_starts
   import pseq_pkg::*;
#(
   parameter bit WARM_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [2:0]        host_sel,
   input  logic [BYTE_W-1:0] host_wdata,
   input  logic [3:0]        trig_vec,
   output logic              fire,
   output logic [BYTE_W-1:0] start_byte
);
   localparam int KINDS = 4;

   logic [BYTE_W-1:0] start_q [KINDS];
   logic [1:0]        pick;

   // R3: one start register per trigger kind, codes 2..5
   for (genvar k = 0; k < KINDS; k++) begin : g_start
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            start_q[k] <= '0;
         else if (host_we && host_sel == 3'(k + 2))
            start_q[k] <= host_wdata;
      end
   end

   // R10: arbitration order chosen by parameter; bit order sleep,wake12,wake3,warm
   if (WARM_FIRST) begin : g_warm_first
      always_comb begin
         if      (trig_vec[3]) pick = 2'd3;
         else if (trig_vec[0]) pick = 2'd0;
         else if (trig_vec[1]) pick = 2'd1;
         else                  pick = 2'd2;
      end
   end else begin : g_warm_last
      always_comb begin
         if      (trig_vec[0]) pick = 2'd0;
         else if (trig_vec[1]) pick = 2'd1;
         else if (trig_vec[2]) pick = 2'd2;
         else                  pick = 2'd3;
      end
   end

   assign fire       = |trig_vec;
   assign start_byte = start_q[pick];
endmodule

// File: rtl/pseq_walker.sv
module pseq_walker
   import pseq_pkg::*;
#(
   parameter int INDEX_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic [BYTE_W-1:0]  start_byte,
   input  logic               tick,
   input  step_t              step,
   output logic [INDEX_W-1:0] rd_idx,
   output logic [MSG_W-1:0]   msg_data,
   output logic               msg_valid,
   output logic               busy,
   output logic               err_flag
);
   localparam int         NUM_INS  = 1 << INDEX_W;
   localparam logic [8:0] LIMIT    = 9'(NUM_INS);

   walk_st_e           st_q;
   logic [INDEX_W-1:0] idx_q;
   logic [BYTE_W-1:0]  cnt_q, link_q;
   logic [MSG_W-1:0]   msg_q;
   logic               vld_q, err_q;
   logic               start_bad, link_bad;

   assign start_bad = {1'b0, start_byte} >= LIMIT;
   assign link_bad  = {1'b0, link_q} >= LIMIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         cnt_q  <= '0;
         link_q <= '0;
         msg_q  <= '0;
         vld_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (fire) begin          // R9: only sampled here
               if (start_bad) begin
                  err_q <= 1'b1;              // R8: bad start
               end else begin
                  err_q <= 1'b0;
                  idx_q <= start_byte[INDEX_W-1:0];
                  st_q  <= ST_FETCH;          // R4
               end
            end
            ST_FETCH: begin                   // R5: strobe with new message
               msg_q  <= step.msg;
               cnt_q  <= step.dly;
               link_q <= step.link;
               vld_q  <= 1'b1;
               st_q   <= ST_WAIT;
            end
            ST_WAIT: if (tick) begin          // R6: d+1 ticks per step
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (link_q == END_MARK) begin
                  st_q <= ST_IDLE;            // R7
               end else if (link_bad) begin
                  err_q <= 1'b1;              // R8
                  st_q  <= ST_IDLE;
               end else begin
                  idx_q <= link_q[INDEX_W-1:0];
                  st_q  <= ST_FETCH;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_idx    = idx_q;
   assign msg_data  = msg_q;
   assign msg_valid = vld_q;
   assign busy      = (st_q != ST_IDLE);
   assign err_flag  = err_q;
endmodule

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine
   import pseq_pkg::*;
#(
   parameter int INDEX_W    = 6,
   parameter bit WARM_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_we,
   input  logic [2:0]  host_sel,
   input  logic [7:0]  host_wdata,
   input  logic        trig_sleep,
   input  logic        trig_wake12,
   input  logic        trig_wake3,
   input  logic        trig_warm,
   input  logic        tick,
   output logic [15:0] msg_data,
   output logic        msg_valid,
   output logic        busy,
   output logic        err_flag
);
   if (INDEX_W < 2 || INDEX_W > 6) begin : g_bad_index_w
      $error("INDEX_W must lie in 2..6 so a byte address fits the host byte");
   end

   logic               fire;
   logic [BYTE_W-1:0]  start_byte;
   logic [INDEX_W-1:0] rd_idx;
   step_t              rd_step;

   pseq_store #(.INDEX_W(INDEX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .rd_idx(rd_idx), .rd_step(rd_step));

   pseq_starts #(.WARM_FIRST(WARM_FIRST)) u_starts (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata),
      .trig_vec({trig_warm, trig_wake3, trig_wake12, trig_sleep}),
      .fire(fire), .start_byte(start_byte));

   pseq_walker #(.INDEX_W(INDEX_W)) u_walker (
      .clk(clk), .rst_n(rst_n), .fire(fire), .start_byte(start_byte),
      .tick(tick), .step(rd_step), .rd_idx(rd_idx), .msg_data(msg_data),
      .msg_valid(msg_valid), .busy(busy), .err_flag(err_flag));
endmodule

// File: rtl/pseq_chk.sv
module pseq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        trig_sleep,
   input logic        trig_wake12,
   input logic        trig_wake3,
   input logic        trig_warm,
   input logic        tick,
   input logic [15:0] msg_data,
   input logic        msg_valid,
   input logic        busy,
   input logic        err_flag
);
   logic any_trig;
   assign any_trig = trig_sleep | trig_wake12 | trig_wake3 | trig_warm;

   p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> !msg_valid);

   p_data_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid |-> $stable(msg_data));

   p_strobe_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> busy);

   p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && any_trig) |=> (busy || err_flag));

   p_first_msg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> msg_valid);

   p_end_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick));

   p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> !busy);
endmodule

bind pwr_seq_engine pseq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .trig_sleep(trig_sleep), .trig_wake12(trig_wake12),
   .trig_wake3(trig_wake3), .trig_warm(trig_warm), .tick(tick),
   .msg_data(msg_data), .msg_valid(msg_valid), .busy(busy), .err_flag(err_flag));

// File: tb/sim_pwr_seq_engine.sv
`timescale 1ns/1ps
module sim_pwr_seq_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [2:0]  host_sel = '0;
   logic [7:0]  host_wdata = '0;
   logic [3:0]  trig = '0;            // sleep, wake12, wake3, warm
   logic        tick = 1'b0;
   logic [15:0] msg_data;
   logic        msg_valid, busy, err_flag;

   always #4 clk = ~clk;              // 125 MHz

   pwr_seq_engine u0 (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .trig_sleep(trig[0]), .trig_wake12(trig[1]),
      .trig_wake3(trig[2]), .trig_warm(trig[3]), .tick(tick),
      .msg_data(msg_data), .msg_valid(msg_valid), .busy(busy), .err_flag(err_flag));

   int checks = 0, fails = 0, cyc = 0;
   logic [15:0] log_msg [32];
   int log_n = 0;
   logic prev_vld = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         finish_up();
      end
   end

   // message monitor; R5 strobe width
   always @(negedge clk) begin
      if (msg_valid && log_n < 32) begin
         log_msg[log_n] = msg_data;
         log_n++;
      end
      if (msg_valid && prev_vld) chk(1'b0, "R5 strobe width", 2, 1);
      prev_vld = msg_valid;
   end

   task automatic host_write(input logic [2:0] sel, input logic [7:0] d);
      host_sel = sel; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic do_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run(input logic [3:0] mask, input int ecnt, input logic [15:0] efirst,
                      input logic [15:0] elast, input int eticks, input logic eerr,
                      input string tag);
      int n_tick = 0;
      log_n = 0;
      trig = mask;
      @(negedge clk);
      trig = '0;
      chk(busy == (ecnt != 0), {tag, " R4 busy after trigger"}, busy, ecnt != 0);
      @(negedge clk);
      while (busy && n_tick < 300) begin
         do_tick();
         n_tick++;
      end
      #1;
      chk(log_n == ecnt, {tag, " R2 message count"}, log_n, ecnt);
      if (ecnt > 0 && log_n > 0) begin
         chk(log_msg[0] == efirst, {tag, " R2 first message"}, log_msg[0], efirst);
         chk(log_msg[log_n-1] == elast, {tag, " R5 last message held"}, msg_data, elast);
      end
      chk(n_tick == eticks, {tag, " R6 R7 tick total"}, n_tick, eticks);
      chk(err_flag == eerr, {tag, " R8 error flag"}, err_flag, eerr);
      chk(!busy, {tag, " R7 idle at end"}, busy, 0);
   endtask

   // step table: index, message, delay, link
   typedef struct packed {
      logic [7:0]  idx;
      logic [15:0] msg;
      logic [7:0]  dly;
      logic [7:0]  link;
   } prog_t;

   localparam prog_t PROG [11] = '{
      '{8'd5,  16'h20F0, 8'd2, 8'd6},
      '{8'd6,  16'h2100, 8'd1, 8'h3F},
      '{8'd10, 16'h1A7E, 8'd0, 8'd11},
      '{8'd11, 16'h217E, 8'd3, 8'd12},
      '{8'd12, 16'h1E7E, 8'd0, 8'h3F},
      '{8'd20, 16'h807E, 8'd0, 8'h3F},
      '{8'd30, 16'h01B0, 8'd1, 8'd31},
      '{8'd31, 16'h20FF, 8'd0, 8'd40},
      '{8'd40, 16'h01BE, 8'd2, 8'h3F},
      '{8'd50, 16'hABCD, 8'd0, 8'h80},
      '{8'd51, 16'h1234, 8'd1, 8'h40}
   };

   // scenario vectors: start register code, start value, trigger, expectations
   typedef struct packed {
      logic [2:0]  sel;
      logic [7:0]  start;
      logic [3:0]  mask;
      logic [3:0]  cnt;
      logic [15:0] first;
      logic [15:0] last;
      logic [7:0]  ticks;
      logic        err;
   } row_t;

   localparam row_t ROWS [8] = '{
      '{3'd2, 8'd5,    4'b0001, 4'd2, 16'h20F0, 16'h2100, 8'd5, 1'b0},
      '{3'd3, 8'd10,   4'b0010, 4'd3, 16'h1A7E, 16'h1E7E, 8'd6, 1'b0},
      '{3'd4, 8'd20,   4'b0100, 4'd1, 16'h807E, 16'h807E, 8'd1, 1'b0},
      '{3'd5, 8'd30,   4'b1000, 4'd3, 16'h01B0, 16'h01BE, 8'd6, 1'b0},
      '{3'd2, 8'd50,   4'b0001, 4'd1, 16'hABCD, 16'hABCD, 8'd1, 1'b1},
      '{3'd5, 8'd51,   4'b1000, 4'd1, 16'h1234, 16'h1234, 8'd2, 1'b1},
      '{3'd3, 8'd10,   4'b0010, 4'd3, 16'h1A7E, 16'h1E7E, 8'd6, 1'b0},
      '{3'd2, 8'h45,   4'b0001, 4'd0, 16'h0000, 16'h0000, 8'd0, 1'b1}
   };

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(busy == 1'b0,      "R11 busy in reset", busy, 0);
      chk(msg_valid == 1'b0, "R11 valid in reset", msg_valid, 0);
      chk(err_flag == 1'b0,  "R11 error in reset", err_flag, 0);
      chk(msg_data == 16'h0, "R11 message in reset", msg_data, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2: load steps through the indirect port
      foreach (PROG[i]) begin
         for (int b = 0; b < 4; b++) begin
            logic [31:0] bytes;
            bytes = {PROG[i].msg, PROG[i].dly, PROG[i].link};
            host_write(3'd0, 8'(PROG[i].idx * 4 + b));
            host_write(3'd1, bytes[31-8*b -: 8]);
         end
      end

      // R3 R6 R7 R8: vector walk
      foreach (ROWS[r]) begin
         host_write(ROWS[r].sel, ROWS[r].start);
         run(ROWS[r].mask, int'(ROWS[r].cnt), ROWS[r].first, ROWS[r].last,
             int'(ROWS[r].ticks), ROWS[r].err, $sformatf("row%0d", r));
      end

      // R9: warm trigger during a wake run is ignored
      host_write(3'd3, 8'd10);
      host_write(3'd5, 8'd30);
      log_n = 0;
      trig = 4'b0010; @(negedge clk); trig = '0;
      @(negedge clk);
      trig = 4'b1000; @(negedge clk); trig = '0;
      while (busy) do_tick();
      #1;
      chk(log_n == 3, "R9 ignored trigger count", log_n, 3);
      chk(msg_data == 16'h1E7E, "R9 ignored trigger last", msg_data, 16'h1E7E);
      chk(!busy, "R9 no restart", busy, 0);

      // R10: same-clock collisions
      host_write(3'd2, 8'd5);
      host_write(3'd4, 8'd20);
      run(4'b1001, 3, 16'h01B0, 16'h01BE, 6, 1'b0, "R10 warm over sleep");
      run(4'b0011, 2, 16'h20F0, 16'h2100, 5, 1'b0, "R10 sleep over wake12");
      run(4'b0110, 3, 16'h1A7E, 16'h1E7E, 6, 1'b0, "R10 wake12 over wake3");

      // R1: repeated data writes land on the same byte; code 6 writes nothing
      host_write(3'd0, 8'd81);
      host_write(3'd1, 8'h00);
      host_write(3'd1, 8'h7D);
      host_write(3'd6, 8'h00);
      run(4'b0100, 1, 16'h807D, 16'h807D, 1, 1'b0, "R1 no auto increment");

      finish_up();
   end
endmodule